// File: doc/BRIEF.md
# Dual-Bank Display Row Buffer

This block holds two rows of character-display data so that one row can be filled while the other is shown. A write port takes one byte for each write-clock enable and places it into the bank that is currently being filled. A read port sends out bytes from the other bank, one for each read-clock enable, to the downstream rendering pipeline. The two ports run in one system clock domain. Each one advances only on the cycles where its own clock-enable input is high.

At the end of each text row, the timing generator pulls the counter-clear strobe low. This falling edge is only recorded when it happens. The clear itself is carried out on the next read-clock enable. At that point the read side always rewinds. The write side rewinds and the two banks trade roles only when the bank-hold input is low. Holding that input high lets the same row be shown again, for example on each scan line of a character cell. Each port has a sticky overflow flag that marks when it has reached the last address of the row.

The two write enables are ANDed together, so a system that needs only one can tie the other high. Both the combined write enable and the read enable are registered. Each takes effect one port-clock later.

Top module: `row_bank_buffer`

## Requirements
- R1: A synchronous reset clears both address counters, both overflow flags, the pending-clear flag, the registered enables and the bank select. After reset, `dout` is 0, `rd_ovf` is 0 and `wr_ovf` is 0, and the bank being written is bank 0.
- R2: A high-to-low change on `cnt_clr` only marks a clear as pending. No counter, flag or bank changes until the next cycle with `rd_tick` high, and that cycle carries out the pending clear.
- R3: A pending clear with `hold_bank` low does all of the following: sets the read address to 0 and clears `rd_ovf`; swaps the two banks, so that the bank just written becomes the bank that is read; sets the write address to 0; and clears `wr_ovf`.
- R4: A pending clear with `hold_bank` high resets only the read address and `rd_ovf`. The bank roles, the write address and `wr_ovf` keep their values, so the same bank is read again from address 0.
- R5: `rd_en` is sampled on every `rd_tick` cycle. A byte is read on a `rd_tick` cycle only if `rd_en` was high at the previous `rd_tick` cycle.
- R6: A read drives the byte stored at the read address of the bank not being written onto `dout`, and the read address then goes up by one. Apart from reads, `dout` holds its value.
- R7: `rd_ovf` goes high when a read brings the read address to DEPTH-1. It stays high until the next clear.
- R8: On a `wr_tick` cycle with both write enables high, `din` is captured into a latch. On the next `wr_tick` cycle, that latched byte is stored at the write address of the bank being written, and the write address goes up by one. The write address comes only from the write counter.
- R9: `wr_ovf` goes high when a store brings the write address to DEPTH-1. It stays high until a clear with `hold_bank` low.
- R10: Writes need `wr_en_a` and `wr_en_b` both high. With only one of them high, nothing is latched and nothing is stored.
- R11: Both address counters stop at DEPTH, which is 135 by default. Once a counter is at DEPTH, that port makes no further read or store until a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DW | Byte written into the fill bank |
| wr_en_a | input | 1 | Write enable, first half of the AND |
| wr_en_b | input | 1 | Write enable, second half of the AND (may be tied high) |
| rd_en | input | 1 | Read enable, registered on `rd_tick` |
| cnt_clr | input | 1 | Counter-clear strobe; its falling edge arms a clear |
| hold_bank | input | 1 | High: a clear rewinds the read side only, with no bank swap |
| rd_tick | input | 1 | Read-port clock enable |
| wr_tick | input | 1 | Write-port clock enable |
| dout | output | DW | Registered byte read from the display bank |
| rd_ovf | output | 1 | Read side reached the last address |
| wr_ovf | output | 1 | Write side reached the last address |

## Verification
A byte presented on `din` reaches memory only on the second `wr_tick` after it is presented. A byte read out appears on `dout` right after the `rd_tick` edge that reads it, but only if `rd_en` was high one `rd_tick` earlier. A clear armed by a falling `cnt_clr` acts only on the following `rd_tick`. The bench drives inputs on falling clock edges and pulses each tick for a single cycle. It checks outputs on the falling edge right after the rising edge of that tick, so every expected value is compared in exactly the cycle it becomes due. The bench also checks that `wr_ovf` still holds its old value while a clear is pending, which shows that the clear is truly deferred.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;
  // Counter width able to hold 0..depth (depth itself is the saturation value).
  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/rowbuf_ram.sv
module rowbuf_ram #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with synchronous reset of the output register only.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rowbuf_wr_side.sv
module rowbuf_wr_side #(
  parameter int DEPTH = 135,
  parameter int DW    = 8,
  parameter int CW    = rowbuf_pkg::cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_tick,
  input  logic          en_a,
  input  logic          en_b,
  input  logic [DW-1:0] din,
  input  logic          rewind,
  output logic          mem_we,
  output logic [CW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [CW-1:0] wr_cnt,
  output logic          wr_ovf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic          en_q;
  logic [DW-1:0] hold_q;
  logic [CW-1:0] wac_q;
  logic [CW-1:0] wac_nxt;
  logic          ovf_q;
  logic          both_en;

  assign both_en   = en_a & en_b;
  assign wac_nxt   = wac_q + CW'(1);
  assign mem_we    = wr_tick & en_q & (wac_q < FULL);
  assign mem_waddr = wac_q;
  assign mem_wdata = hold_q;
  assign wr_cnt    = wac_q;
  assign wr_ovf    = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wac_q <= '0;
      ovf_q <= 1'b0;
    end else if (rewind) begin
      wac_q <= '0;
      ovf_q <= 1'b0;
    end else if (mem_we) begin
      wac_q <= wac_nxt;
      if (wac_nxt == LAST) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      hold_q <= '0;
    end else if (wr_tick) begin
      en_q <= both_en;
      if (both_en) hold_q <= din;
    end
  end
endmodule

// File: rtl/rowbuf_rd_side.sv
module rowbuf_rd_side #(
  parameter int DEPTH = 135,
  parameter int CW    = rowbuf_pkg::cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_tick,
  input  logic          rd_en,
  input  logic          rewind,
  output logic          mem_re,
  output logic [CW-1:0] mem_raddr,
  output logic [CW-1:0] rd_cnt,
  output logic          rd_ovf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic          en_q;
  logic [CW-1:0] rac_q;
  logic [CW-1:0] rac_eff;
  logic [CW-1:0] rac_nxt;
  logic          ovf_q;

  // A rewind on this tick takes effect before the read of the same tick.
  assign rac_eff   = rewind ? '0 : rac_q;
  assign rac_nxt   = rac_eff + CW'(1);
  assign mem_re    = rd_tick & en_q & (rac_eff < FULL);
  assign mem_raddr = rac_eff;
  assign rd_cnt    = rac_q;
  assign rd_ovf    = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      rac_q <= '0;
      ovf_q <= 1'b0;
    end else if (rd_tick) begin
      en_q <= rd_en;
      if (rewind) begin
        rac_q <= '0;
        ovf_q <= 1'b0;
      end
      if (mem_re) begin
        rac_q <= rac_nxt;
        if (rac_nxt == LAST) ovf_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/row_bank_buffer.sv
module row_bank_buffer #(
  parameter int DEPTH = 135,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          wr_en_a,
  input  logic          wr_en_b,
  input  logic          rd_en,
  input  logic          cnt_clr,
  input  logic          hold_bank,
  input  logic          rd_tick,
  input  logic          wr_tick,
  output logic [DW-1:0] dout,
  output logic          rd_ovf,
  output logic          wr_ovf
);
  localparam int CW = rowbuf_pkg::cnt_width(DEPTH);
  localparam int AW = CW + 1;

  logic          clr_prev;
  logic          clr_fall;
  logic          pend_q;
  logic          bank_q;
  logic          do_clr;
  logic          do_swap;
  logic          rd_bank;
  logic          mem_we;
  logic          mem_re;
  logic [CW-1:0] wr_addr;
  logic [CW-1:0] rd_addr;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] wr_cnt;
  logic [CW-1:0] rd_cnt;

  // Edge detector follows the pin even through reset, so no false edge appears.
  always_ff @(posedge clk) clr_prev <= cnt_clr;

  assign clr_fall = clr_prev & ~cnt_clr;
  assign do_clr   = rd_tick & pend_q;
  assign do_swap  = do_clr & ~hold_bank;
  assign rd_bank  = ~(bank_q ^ do_swap);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      bank_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~rd_tick) | clr_fall;
      if (do_swap) bank_q <= ~bank_q;
    end
  end

  rowbuf_wr_side #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) wr_i (
    .clk       (clk),
    .rst       (rst),
    .wr_tick   (wr_tick),
    .en_a      (wr_en_a),
    .en_b      (wr_en_b),
    .din       (din),
    .rewind    (do_swap),
    .mem_we    (mem_we),
    .mem_waddr (wr_addr),
    .mem_wdata (wr_data),
    .wr_cnt    (wr_cnt),
    .wr_ovf    (wr_ovf)
  );

  rowbuf_rd_side #(.DEPTH(DEPTH), .CW(CW)) rd_i (
    .clk       (clk),
    .rst       (rst),
    .rd_tick   (rd_tick),
    .rd_en     (rd_en),
    .rewind    (do_clr),
    .mem_re    (mem_re),
    .mem_raddr (rd_addr),
    .rd_cnt    (rd_cnt),
    .rd_ovf    (rd_ovf)
  );

  rowbuf_ram #(.DW(DW), .AW(AW)) ram_i (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr ({bank_q, wr_addr}),
    .wdata (wr_data),
    .re    (mem_re),
    .raddr ({rd_bank, rd_addr}),
    .rdata (dout)
  );
endmodule

// File: rtl/rowbuf_chk.sv
module rowbuf_chk #(
  parameter int DEPTH = 135,
  parameter int DW    = 8,
  parameter int CW    = rowbuf_pkg::cnt_width(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_tick,
  input logic          cnt_clr,
  input logic          hold_bank,
  input logic [DW-1:0] dout,
  input logic          rd_ovf,
  input logic          wr_ovf,
  input logic          bank_q,
  input logic          pend_q,
  input logic [CW-1:0] rd_cnt,
  input logic [CW-1:0] wr_cnt
);
  AST_CLR_ARMS: assert property (@(posedge clk) disable iff (rst)
    $fell(cnt_clr) |=> pend_q); // R2
  AST_SWAP_ON_RTICK: assert property (@(posedge clk) disable iff (rst)
    !rd_tick |=> $stable(bank_q)); // R3
  AST_HOLD_NO_SWAP: assert property (@(posedge clk) disable iff (rst)
    (rd_tick && pend_q && hold_bank) |=> $stable(bank_q)); // R4
  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_tick |=> $stable(dout)); // R6
  AST_RD_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
    rd_ovf |-> (rd_cnt >= CW'(DEPTH - 1))); // R7
  AST_WR_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
    wr_ovf |-> (wr_cnt >= CW'(DEPTH - 1))); // R9
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (rd_cnt <= CW'(DEPTH)) && (wr_cnt <= CW'(DEPTH))); // R11
endmodule

bind row_bank_buffer rowbuf_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rd_tick   (rd_tick),
  .cnt_clr   (cnt_clr),
  .hold_bank (hold_bank),
  .dout      (dout),
  .rd_ovf    (rd_ovf),
  .wr_ovf    (wr_ovf),
  .bank_q    (bank_q),
  .pend_q    (pend_q),
  .rd_cnt    (rd_cnt),
  .wr_cnt    (wr_cnt)
);

// File: tb/row_bank_buffer_tb_top.sv
module row_bank_buffer_tb_top;
  localparam int D = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic       wr_en_a = 1'b0, wr_en_b = 1'b0, rd_en = 1'b0;
  logic       cnt_clr = 1'b1, hold_bank = 1'b0;
  logic       rd_tick = 1'b0, wr_tick = 1'b0;
  logic [7:0] dout;
  logic       rd_ovf, wr_ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  row_bank_buffer #(.DEPTH(D), .DW(8)) dut_i (
    .clk(clk), .rst(rst), .din(din), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
    .rd_en(rd_en), .cnt_clr(cnt_clr), .hold_bank(hold_bank),
    .rd_tick(rd_tick), .wr_tick(wr_tick), .dout(dout),
    .rd_ovf(rd_ovf), .wr_ovf(wr_ovf)
  );

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'(p * 40 + i * 3 + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wtick(input bit a, input bit b, input logic [7:0] d);
    @(negedge clk);
    wr_en_a = a; wr_en_b = b; din = d; wr_tick = 1'b1;
    @(negedge clk);
    wr_tick = 1'b0;
  endtask

  task automatic rtick(input bit en);
    @(negedge clk);
    rd_en = en; rd_tick = 1'b1;
    @(negedge clk);
    rd_tick = 1'b0;
  endtask

  // Fill one row with pattern p; each stored byte lands one tick after it is latched.
  task automatic write_row(input int p);
    for (int t = 1; t <= D + 1; t++) begin
      wtick(1'b1, 1'b1, pat(p, t - 1));
      chk("R9 wr_ovf while filling", int'(wr_ovf), int'(t >= D));
    end
    wtick(1'b0, 1'b1, 8'h00);
    chk("R11 wr_ovf after saturation", int'(wr_ovf), 1);
  endtask

  task automatic arm_clear();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    @(negedge clk); cnt_clr = 1'b1;
  endtask

  // Clear tick with rd_en high: no read yet (registered enable was low).
  task automatic do_clear(input bit hold);
    logic [7:0] prev;
    hold_bank = hold;
    arm_clear();
    prev = dout;
    rtick(1'b1);
    hold_bank = 1'b0;
    chk("R5 no read on enabling tick", int'(dout), int'(prev));
    chk("R3 rd_ovf cleared", int'(rd_ovf), 0);
  endtask

  task automatic read_row(input int p);
    for (int k = 0; k < D; k++) begin
      rtick(1'b1);
      chk("R6 dout from display bank", int'(dout), int'(pat(p, k)));
      chk("R7 rd_ovf", int'(rd_ovf), int'(k + 1 >= D - 1));
    end
    rtick(1'b0);
    chk("R11 read saturated, dout holds", int'(dout), int'(pat(p, D - 1)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dout after reset", int'(dout), 0);
    chk("R1 rd_ovf after reset", int'(rd_ovf), 0);
    chk("R1 wr_ovf after reset", int'(wr_ovf), 0);

    write_row(0);                       // R8 bank 0 filled
    arm_clear();
    repeat (3) @(negedge clk);
    chk("R2 clear deferred until rd_tick", int'(wr_ovf), 1);
    begin
      logic [7:0] prev;
      prev = dout;
      rtick(1'b1);
      chk("R3 wr_ovf cleared by swap", int'(wr_ovf), 0);
      chk("R5 no read on enabling tick", int'(dout), int'(prev));
    end
    read_row(0);                        // R8 stored data read back

    write_row(1);                       // bank 1
    do_clear(1'b0);
    chk("R3 wr_ovf after swap", int'(wr_ovf), 0);
    write_row(2);                       // bank 0
    read_row(1);

    do_clear(1'b1);
    chk("R4 wr_ovf kept on hold clear", int'(wr_ovf), 1);
    read_row(1);                        // R4 same bank again

    do_clear(1'b0);
    read_row(2);                        // bank 1 now written, holds pattern 1

    for (int t = 0; t < D + 2; t++) begin
      wtick(1'b1, 1'b0, pat(3, t));
      chk("R10 single enable a", int'(wr_ovf), 0);
    end
    for (int t = 0; t < D + 2; t++) begin
      wtick(1'b0, 1'b1, pat(4, t));
      chk("R10 single enable b", int'(wr_ovf), 0);
    end
    do_clear(1'b0);
    read_row(1);                        // R10 bank 1 untouched

    write_row(5);                       // bank 0, wr_en_b tied high style
    do_clear(1'b0);
    read_row(5);

    // R5: dropping rd_en still reads once, then stops.
    do_clear(1'b1);
    rtick(1'b0);
    chk("R5 registered enable reads once", int'(dout), int'(pat(5, 0)));
    rtick(1'b0);
    chk("R5 read stops after enable drop", int'(dout), int'(pat(5, 0)));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule